// File: doc/BRIEF.md
# Byte-Lane Pseudo-Static RAM Model

This block is a synthesizable, cycle-based stand-in for a 16-bit pseudo-static memory. It serves as the target when a memory controller is verified. All inputs are sampled on the rising clock edge. The control inputs are active-low: chip select, output enable, write enable, and one strobe for each byte lane. A MODE input selects which standby behaviour applies while the chip is deselected. Each lane has its own read path and its own store. Read data comes back one cycle after the request, together with a per-lane drive enable that lets the surrounding logic build a tri-state bus.

The model keeps a lane-level record of which stored bytes still hold meaningful data. It also follows the power-up protocol. After reset, or after the data-losing standby, the model refuses writes. First it needs a quiet wait with chip select and MODE both high. Then it needs three dummy reads, each started by a falling chip select. Protocol misuse is reported on single-cycle error outputs: a refused write, bus contention on a lane, or MODE low while the chip is selected.

Top module: `psram_model`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `init_done`=0, `dq_oe`=00, `rd_unk`=00, and all three error flags 0.
- R2: `init_done` rises only after both of the following, in order. First, WAIT_CYC edges in a row that sample `cs_n`=1 and `mode`=1. Second, three edges that each sample a `cs_n` falling edge with `we_n`=1 and `mode`=1. It rises at the edge of the third such read.
- R3: A write attempt while `init_done`=0 stores nothing. A write attempt means `cs_n`=0, `we_n`=0 and at least one strobe low. One cycle later `err_access` pulses, and once the model is ready the targeted bytes read back with `rd_unk` set.
- R4: Bit 0 of the strobe pair is `lb_n`, which gates data bits 7:0. Bit 1 is `ub_n`, which gates bits 15:8. A write changes only the lanes whose strobe is low.
- R5: A write cycle with both strobes high is aborted and leaves memory unchanged.
- R6: When `cs_n`=0, `we_n`=1 and `oe_n`=0, each lane whose strobe is low has `dq_oe` set one cycle later, with the stored byte on `dq_out`. A lane whose strobe is high keeps `dq_oe` low.
- R7: Any edge that samples `we_n`=0 leaves `dq_oe`=00 in the following cycle, whatever `oe_n` is.
- R8: A write stores the data present at the last edge of an unbroken overlap of `cs_n`, `we_n` and the lane strobe being low. Edges inside that run with the lane strobe high store nothing.
- R9: `cs_n`=1 with `mode`=1 keeps both the stored data and the ready state for any length of time.
- R10: An edge sampling `cs_n`=1 and `mode`=0 clears `init_done` one cycle later and marks every stored byte invalid. After re-initialization, a read of a byte not rewritten since then returns `rd_unk`=1 on that lane.
- R11: `err_bus` is high in the cycle after an edge at which `dq_drv` and `dq_oe` overlap on any lane.
- R12: `err_mode` is high in the cycle after an edge that samples `cs_n`=0 with `mode`=0.
- R13: A read issued while not ready drives its lanes with `dq_out` bytes 0 and `rd_unk` set on those lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lb_n | input | 1 | Lower byte strobe (bits 7:0), active low |
| ub_n | input | 1 | Upper byte strobe (bits 15:8), active low |
| mode | input | 1 | Standby selector; low while deselected discards contents |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| dq_in | input | 16 | Write data from the controller |
| dq_drv | input | 2 | Per-lane flag: the controller is driving that lane |
| dq_out | output | 16 | Read data |
| dq_oe | output | 2 | Per-lane drive enable of the model |
| rd_unk | output | 2 | Per-lane flag: read data is not trustworthy |
| init_done | output | 1 | Initialization complete |
| err_access | output | 1 | Pulse: write refused before ready |
| err_bus | output | 1 | Pulse: lane contention detected |
| err_mode | output | 1 | Pulse: MODE low while selected |

## Verification
Completing initialization and judging a read can fall on the same edge. The bench makes the third dummy read a real one, with output enable and both strobes low. At that edge `init_done` rises, yet the read it launches was judged against the old state, so the bench expects both lanes driven, zero data and `rd_unk`=11 in that very cycle. The other coincidence is a controller drive landing on a lane the model is already driving. The bench provokes it by raising `dq_drv` while a read is held, and expects `err_bus` exactly one cycle later while the read data stays on the bus.

// File: rtl/psram_pkg.sv
// Shared types and constants of the pseudo-static RAM model.
package psram_pkg;
    localparam int LANES       = 2;
    localparam int LANE_W      = 8;
    localparam int WORD_W      = LANES * LANE_W;
    localparam int DUMMY_READS = 3;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_DUMMY = 2'd1,
        ST_READY = 2'd2
    } init_st_t;
endpackage

// File: rtl/psram_init_ctrl.sv
// Power-up / re-initialization sequencer.
// Requires WAIT_CYC edges with cs_n and mode high, then DUMMY_READS falling
// chip-select reads with we_n and mode high. Any deselect with mode low
// (data-losing standby) restarts the sequence and requests a wipe.
// Assumes inputs are synchronous to clk.
module psram_init_ctrl
    import psram_pkg::*;
#(
    parameter int WAIT_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic we_n,
    input  logic mode,
    output logic ready,
    output logic wipe
);
    localparam int WCW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam int RCW = $clog2(DUMMY_READS + 1);

    init_st_t        st;
    logic [WCW-1:0]  wcnt;
    logic [RCW-1:0]  rcnt;
    logic            cs_prev;
    logic            dummy_rd;

    assign wipe     = cs_n && !mode;
    assign dummy_rd = cs_prev && !cs_n && we_n && mode;
    assign ready    = (st == ST_READY);

    // Sequence state, quiet-time counter and dummy-read counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_WAIT;
            wcnt    <= '0;
            rcnt    <= '0;
            cs_prev <= 1'b1;
        end else begin
            cs_prev <= cs_n;
            if (wipe) begin
                st   <= ST_WAIT;
                wcnt <= '0;
                rcnt <= '0;
            end else begin
                unique case (st)
                    ST_WAIT: begin
                        if (cs_n && mode) begin
                            if (wcnt == WCW'(WAIT_CYC - 1)) begin
                                st   <= ST_DUMMY;
                                rcnt <= '0;
                            end else begin
                                wcnt <= wcnt + 1'b1;
                            end
                        end else begin
                            wcnt <= '0;
                        end
                    end
                    ST_DUMMY: begin
                        if (dummy_rd) begin
                            if (rcnt == RCW'(DUMMY_READS - 1)) st <= ST_READY;
                            else                              rcnt <= rcnt + 1'b1;
                        end
                    end
                    default: st <= st;
                endcase
            end
        end
    end
endmodule

// File: rtl/psram_lane.sv
// One byte lane: storage, per-word validity bit and registered read port.
// A read returns zero data and the unknown flag when the device is not ready,
// the address is beyond DEPTH, or the byte was never written since the last
// wipe. Storage has no reset; validity is cleared by reset or wipe.
module psram_lane
    import psram_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              ready,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout,
    output logic              doe,
    output logic              unk
);
    logic [LANE_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  valid;
    logic              in_range;

    assign in_range = ({1'b0, addr} < (AW + 1)'(DEPTH));

    // Byte storage, written at every edge of a valid overlap.
    always_ff @(posedge clk) begin
        if (wr_en && in_range) mem[addr] <= din;
    end

    // Validity record, cleared on reset or data-losing standby.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe)            valid       <= '0;
        else if (wr_en && in_range)    valid[addr] <= 1'b1;
    end

    // Registered read port and lane drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            doe  <= 1'b0;
            dout <= '0;
            unk  <= 1'b0;
        end else begin
            doe  <= rd_en;
            dout <= (rd_en && ready && in_range) ? mem[addr] : '0;
            unk  <= rd_en && (!ready || !in_range || !valid[addr]);
        end
    end
endmodule

// File: rtl/psram_model.sv
// Top of the pseudo-static RAM model: decodes the control pins, gates writes
// on initialization, drives per-lane read enables and flags protocol misuse.
// Assumes all inputs are synchronous to clk; the bus is split into in/out/oe.
module psram_model
    import psram_pkg::*;
#(
    parameter int DEPTH    = 1024,
    parameter int WAIT_CYC = 10000,
    localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic              mode,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] dq_in,
    input  logic [LANES-1:0]  dq_drv,
    output logic [WORD_W-1:0] dq_out,
    output logic [LANES-1:0]  dq_oe,
    output logic [LANES-1:0]  rd_unk,
    output logic              init_done,
    output logic              err_access,
    output logic              err_bus,
    output logic              err_mode
);
    logic [LANES-1:0] strobe_n;
    logic             ready;
    logic             wipe;

    assign strobe_n  = {ub_n, lb_n};
    assign init_done = ready;

    psram_init_ctrl #(.WAIT_CYC(WAIT_CYC)) u_init (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .we_n  (we_n),
        .mode  (mode),
        .ready (ready),
        .wipe  (wipe)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic rd_en;
        logic wr_en;
        assign rd_en = !cs_n && we_n && !oe_n && !strobe_n[g];
        assign wr_en = !cs_n && !we_n && !strobe_n[g] && ready;

        psram_lane #(.DEPTH(DEPTH), .AW(AW)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .wipe  (wipe),
            .ready (ready),
            .wr_en (wr_en),
            .rd_en (rd_en),
            .addr  (addr),
            .din   (dq_in[g*LANE_W +: LANE_W]),
            .dout  (dq_out[g*LANE_W +: LANE_W]),
            .doe   (dq_oe[g]),
            .unk   (rd_unk[g])
        );
    end

    // Protocol-violation pulses, one cycle after the offending edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_access <= 1'b0;
            err_bus    <= 1'b0;
            err_mode   <= 1'b0;
        end else begin
            err_access <= !cs_n && !we_n && !(&strobe_n) && !ready;
            err_bus    <= |(dq_drv & dq_oe);
            err_mode   <= !cs_n && !mode;
        end
    end
endmodule

// File: rtl/psram_model_chk.sv
// Protocol checker for psram_model, attached through bind below.
module psram_model_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       oe_n,
    input logic       we_n,
    input logic       lb_n,
    input logic       ub_n,
    input logic       mode,
    input logic [1:0] dq_oe,
    input logic       init_done,
    input logic       err_access,
    input logic       err_mode
);
    // R7
    we_low_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> dq_oe == 2'b00);

    // R6
    lower_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lb_n |=> !dq_oe[0]);

    // R6
    upper_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ub_n |=> !dq_oe[1]);

    // R6
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && !oe_n && !lb_n) |=> dq_oe[0]);

    // R3
    early_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && !cs_n && !we_n && !(lb_n && ub_n)) |=> err_access);

    // R10
    deep_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !mode) |=> !init_done);

    // R2
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(!cs_n && we_n && mode));

    // R12
    mode_misuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !mode) |=> err_mode);

    // unused in properties above but kept visible to the checker
    logic unused_ok;
    assign unused_ok = oe_n;
endmodule

bind psram_model psram_model_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .lb_n       (lb_n),
    .ub_n       (ub_n),
    .mode       (mode),
    .dq_oe      (dq_oe),
    .init_done  (init_done),
    .err_access (err_access),
    .err_mode   (err_mode)
);

// File: tb/psram_model_bench.sv
module psram_model_bench;
    localparam int DEPTH = 16;
    localparam int WAITC = 8;
    localparam int AW    = 4;

    logic        clk = 1'b0;
    logic        rst_n, cs_n, oe_n, we_n, lb_n, ub_n, mode;
    logic [AW-1:0] addr;
    logic [15:0] dq_in, dq_out;
    logic [1:0]  dq_drv, dq_oe, rd_unk;
    logic        init_done, err_access, err_bus, err_mode;

    int total = 0;
    int bad   = 0;
    logic [15:0] model [DEPTH];

    always #10 clk = ~clk;

    psram_model #(.DEPTH(DEPTH), .WAIT_CYC(WAITC)) u_psram_model (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .lb_n(lb_n), .ub_n(ub_n), .mode(mode), .addr(addr), .dq_in(dq_in),
        .dq_drv(dq_drv), .dq_out(dq_out), .dq_oe(dq_oe), .rd_unk(rd_unk),
        .init_done(init_done), .err_access(err_access), .err_bus(err_bus),
        .err_mode(err_mode)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        cs_n = 1; oe_n = 1; we_n = 1; lb_n = 1; ub_n = 1; mode = 1; dq_drv = 0;
    endtask

    task automatic wr(input int a, input logic [15:0] d, input logic l, input logic u);
        cs_n = 0; we_n = 0; oe_n = 1; lb_n = l; ub_n = u; addr = AW'(a); dq_in = d;
        step();
        idle();
        step();
    endtask

    task automatic rd(input int a, input logic l, input logic u,
                      output logic [15:0] d, output logic [1:0] oe, output logic [1:0] unk);
        cs_n = 0; we_n = 1; oe_n = 0; lb_n = l; ub_n = u; addr = AW'(a);
        step();
        d = dq_out; oe = dq_oe; unk = rd_unk;
        idle();
        step();
    endtask

    // quiet wait then three dummy reads; the third one is a real read (R2)
    task automatic do_init();
        idle();
        repeat (WAITC + 2) step();
        check("R2 not ready after wait", 32'(init_done), 0);
        for (int i = 0; i < 3; i++) begin
            cs_n = 0;
            if (i == 2) begin oe_n = 0; lb_n = 0; ub_n = 0; end
            step();
            if (i == 1) check("R2 not ready after two reads", 32'(init_done), 0);
            if (i == 2) begin
                check("R2 ready at third read", 32'(init_done), 1);
                check("R13 same-edge read judged not ready", 32'({dq_oe, rd_unk}), 32'h0F);
                check("R13 same-edge data zero", 32'(dq_out), 0);
            end
            idle();
            step();
        end
    endtask

    function automatic logic [15:0] fword(input int a);
        return 16'((a * 16'h1357) ^ 16'hA5C3);
    endfunction

    function automatic logic [7:0] fbyte(input int a);
        return 8'((a * 29 + 7) & 8'hFF);
    endfunction

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [1:0]  oe, unk;
        idle(); addr = 0; dq_in = 0; rst_n = 0;
        repeat (3) step();
        // R1 reset state
        check("R1 init_done", 32'(init_done), 0);
        check("R1 dq_oe", 32'(dq_oe), 0);
        check("R1 rd_unk", 32'(rd_unk), 0);
        check("R1 errors", 32'({err_access, err_bus, err_mode}), 0);
        rst_n = 1;
        step();

        // R13 read before ready
        rd(3, 0, 0, d, oe, unk);
        check("R13 lanes driven", 32'(oe), 32'h3);
        check("R13 data zero", 32'(d), 0);
        check("R13 unknown flag", 32'(unk), 32'h3);

        // R3 write refused before ready
        cs_n = 0; we_n = 0; lb_n = 0; ub_n = 0; addr = 5; dq_in = 16'h1234;
        step();
        check("R3 err_access pulse", 32'(err_access), 1);
        idle(); step();
        check("R3 err_access clears", 32'(err_access), 0);

        do_init();
        rd(5, 0, 0, d, oe, unk);
        check("R3 refused write left byte invalid", 32'(unk), 32'h3);

        // R4/R6 full word sweep
        for (int a = 0; a < DEPTH; a++) begin
            wr(a, fword(a), 0, 0);
            model[a] = fword(a);
        end
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, 0, 0, d, oe, unk);
            check("R6 word read", 32'(d), 32'(model[a]));
            check("R6 word drive", 32'({oe, unk}), 32'hC);
        end
        // R4 byte-lane writes: even addresses lower, odd addresses upper
        for (int a = 0; a < DEPTH; a++) begin
            if (a % 2 == 0) begin
                wr(a, {8'hEE, fbyte(a)}, 0, 1);
                model[a][7:0] = fbyte(a);
            end else begin
                wr(a, {fbyte(a), 8'hEE}, 1, 0);
                model[a][15:8] = fbyte(a);
            end
        end
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, 0, 0, d, oe, unk);
            check("R4 byte merge", 32'(d), 32'(model[a]));
        end
        rd(6, 0, 1, d, oe, unk);
        check("R6 lower only drive", 32'(oe), 32'h1);
        check("R6 lower only data", 32'(d[7:0]), 32'(model[6][7:0]));
        rd(7, 1, 0, d, oe, unk);
        check("R6 upper only drive", 32'(oe), 32'h2);
        check("R6 upper only data", 32'(d[15:8]), 32'(model[7][15:8]));

        // R6/R7 control sweep on scratch address 15
        for (int c = 0; c < 16; c++) begin
            logic w, o, l, u;
            {w, o, l, u} = 4'(c);
            cs_n = 0; we_n = w; oe_n = o; lb_n = l; ub_n = u; addr = 15; dq_in = 16'h0F0F;
            step();
            check("R7 R6 drive enables", 32'(dq_oe),
                  32'({w & ~o & ~u, w & ~o & ~l}));
            idle(); step();
        end
        model[15] = 16'h0F0F;

        // R5 aborted write
        cs_n = 0; we_n = 0; lb_n = 1; ub_n = 1; addr = 2; dq_in = 16'hFFFF;
        step(); idle(); step();
        rd(2, 0, 0, d, oe, unk);
        check("R5 abort keeps data", 32'(d), 32'(model[2]));

        // R8 last overlap cycle wins
        cs_n = 0; we_n = 0; lb_n = 0; ub_n = 0; addr = 4; dq_in = 16'hAAAA;
        step();
        dq_in = 16'hBBBB; step();
        we_n = 1; dq_in = 16'h1111; step();
        idle(); step();
        rd(4, 0, 0, d, oe, unk);
        check("R8 end of overlap value", 32'(d), 32'hBBBB);
        cs_n = 0; we_n = 0; lb_n = 1; ub_n = 1; addr = 4; dq_in = 16'hCCCC;
        step();
        lb_n = 0; ub_n = 0; dq_in = 16'hDDDD; step();
        lb_n = 1; ub_n = 1; dq_in = 16'hEEEE; step();
        idle(); step();
        rd(4, 0, 0, d, oe, unk);
        check("R8 strobe-started write", 32'(d), 32'hDDDD);
        model[4] = 16'hDDDD;

        // R11 contention while the model drives
        cs_n = 0; we_n = 1; oe_n = 0; lb_n = 0; ub_n = 0; addr = 1;
        step();
        dq_drv = 2'b10; step();
        check("R11 contention flagged", 32'(err_bus), 1);
        check("R11 read still driven", 32'(dq_out), 32'(model[1]));
        dq_drv = 0; step();
        check("R11 flag clears", 32'(err_bus), 0);
        idle(); step();
        dq_drv = 2'b11; step();
        check("R11 no flag when model idle", 32'(err_bus), 0);
        idle(); step();

        // R12 mode low while selected
        cs_n = 0; mode = 0; step();
        check("R12 err_mode", 32'(err_mode), 1);
        check("R12 still ready", 32'(init_done), 1);
        idle(); step();
        check("R12 err_mode clears", 32'(err_mode), 0);

        // R9 standby keeping data
        repeat (50) step();
        check("R9 ready kept", 32'(init_done), 1);
        rd(0, 0, 0, d, oe, unk);
        check("R9 data kept", 32'(d), 32'(model[0]));

        // R10 data-losing standby
        mode = 0; step();
        check("R10 ready dropped", 32'(init_done), 0);
        mode = 1;
        do_init();
        rd(0, 0, 0, d, oe, unk);
        check("R10 byte invalid", 32'(unk), 32'h3);
        wr(0, 16'h5A5A, 0, 1);
        rd(0, 0, 0, d, oe, unk);
        check("R10 rewritten lane valid", 32'(unk), 32'h2);
        check("R10 rewritten lane data", 32'(d[7:0]), 32'h5A);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule